// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves a single active-low external interrupt pin of a small microcontroller. The pin is brought into the clock domain through a flip-flop synchronizer. A falling edge, or a low level when level sensitivity is selected, sets a pending-request latch. The latch feeds a registered, maskable request line towards the interrupt priority logic. The synchronized pin level is also exported so that the core can execute branch-on-pin-state instructions.

The pending latch is cleared by a vector-fetch acknowledge from the core, by writing a one to a self-clearing acknowledge bit in the 8-bit control/status register, or by reset. With edge sensitivity alone, any one of these clears it. With edge-and-level sensitivity, an acknowledge is remembered internally. The latch is then released only once the pin has also been seen high again, whether the pin rises before or after the acknowledge.

Register layout: bit 0 is the level-sensitivity enable (read/write) and bit 1 is the request mask (read/write). Bit 2 is the acknowledge, which is write-only and reads 0. Bit 3 is the pending flag (read-only), and bits 7..4 read 0.

Top module: `irq_pin_ctrl`

## Requirements
- R1: `pin_level` follows `pin_n` with a delay of two clock edges, and reset has no effect on its value.
- R2: A falling edge on `pin_n` sets the pending flag (register bit 3) on the third clock edge after the pin drops.
- R3: With bit 0 = 0 (edge only), a `vec_ack` pulse or a register write with bit 2 = 1 clears the flag on that edge, even while the pin stays low. A pin held low does not set the flag again.
- R4: With bit 0 = 1 (edge and level), an acknowledge given while the pin is low leaves the flag set. The flag clears one edge after the synchronized pin is seen high.
- R5: With bit 0 = 1, the pin returning high without an acknowledge leaves the flag set. A later acknowledge clears it on the acknowledge edge.
- R6: With bit 0 = 1, a low synchronized pin level sets a clear flag even when no falling edge occurs.
- R7: While mask bit 1 = 1, `irq_req` stays 0 and the flag still captures events. `irq_req` rises one edge after the mask is cleared.
- R8: `irq_req` is the registered value of flag AND NOT mask, so it rises one edge after the flag.
- R9: A write with `bus_sel` = 1 and `bus_we` = 1 loads bits 1..0. A read returns {0000, flag, 0, mask, mode}, and returns 0 when `bus_sel` = 0.
- R10: An acknowledge that coincides with a detected falling edge leaves the flag set.
- R11: Reset clears the flag, mask and mode bits even when the pin is held low, and no request follows the release of reset.
- R12: A write strobe with `bus_sel` = 0 changes no register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, held at least 3 cycles |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| vec_ack | input | 1 | Vector-fetch acknowledge pulse from the core |
| bus_sel | input | 1 | Register select |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq_req | output | 1 | Masked, registered interrupt request |
| pin_level | output | 1 | Synchronized pin level |

## Verification
A wrong pending flag appears directly in bit 3 of the register read, within the same cycle, and one edge later on `irq_req`. A stale internal acknowledge memory only shows in level mode. It appears as a flag that stays set after the pin returns high, or as a flag that clears early while the pin is still low, visible one edge after the pin's synchronized rise. A synchronizer with the wrong depth shifts every flag and level observation by one cycle, so exact-edge sampling catches it at once.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
    localparam int REG_W    = 8;
    localparam int MODE_BIT = 0;
    localparam int MASK_BIT = 1;
    localparam int ACK_BIT  = 2;
    localparam int FLAG_BIT = 3;

    typedef struct packed {
        logic mask;
        logic level_mode;
    } irq_cfg_t;

    typedef struct packed {
        logic level;
        logic fall;
    } pin_evt_t;

    function automatic logic [REG_W-1:0] pack_status(logic flag, irq_cfg_t cfg);
        logic [REG_W-1:0] v;
        v = '0;
        v[FLAG_BIT] = flag;
        v[MASK_BIT] = cfg.mask;
        v[MODE_BIT] = cfg.level_mode;
        return v;
    endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync
    import irq_pin_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     pin_n,
    output pin_evt_t evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) chain[0] <= pin_n;

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) chain[i] <= chain[i-1];
    end

    always_ff @(posedge clk) prev_q <= chain[LAST];

    always_comb begin
        evt.level = chain[LAST];
        evt.fall  = prev_q & ~chain[LAST];
    end
endmodule

// File: rtl/irq_pin_regs.sv
module irq_pin_regs
    import irq_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             flag,
    output irq_cfg_t         cfg,
    output logic             sw_ack,
    output logic [REG_W-1:0] rdata
);
    logic wr_en;
    assign wr_en  = sel & we;
    assign sw_ack = wr_en & wdata[ACK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.mask       <= wdata[MASK_BIT];
            cfg.level_mode <= wdata[MODE_BIT];
        end
    end

    assign rdata = sel ? pack_status(flag, cfg) : '0;

    // R9
    cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && we) |=> (cfg.mask == $past(wdata[MASK_BIT]) &&
                         cfg.level_mode == $past(wdata[MODE_BIT])));

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(cfg));
endmodule

// File: rtl/irq_pin_latch.sv
module irq_pin_latch
    import irq_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_evt_t evt,
    input  logic     level_mode,
    input  logic     clr,
    output logic     flag
);
    logic flag_q, acked_q, set_ev;

    assign set_ev = evt.fall | (level_mode & ~evt.level & ~flag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            acked_q <= 1'b0;
        end else if (set_ev) begin
            flag_q  <= 1'b1;
            acked_q <= 1'b0;
        end else if (flag_q && (clr || acked_q)) begin
            if (!level_mode || evt.level) begin
                flag_q  <= 1'b0;
                acked_q <= 1'b0;
            end else begin
                acked_q <= 1'b1;
            end
        end
    end

    assign flag = flag_q;

    // R2 R10
    fall_sets_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> flag_q);

    // R3
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && clr && !evt.fall && !level_mode) |=> !flag_q);

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && level_mode && !evt.level) |=> flag_q);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !flag_q);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_n,
    input  logic             vec_ack,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_req,
    output logic             pin_level
);
    pin_evt_t evt;
    irq_cfg_t cfg;
    logic     flag, sw_ack;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .pin_n (pin_n),
        .evt   (evt)
    );

    irq_pin_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .sel    (bus_sel),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .flag   (flag),
        .cfg    (cfg),
        .sw_ack (sw_ack),
        .rdata  (bus_rdata)
    );

    irq_pin_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .level_mode (cfg.level_mode),
        .clr        (vec_ack | sw_ack),
        .flag       (flag)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_req <= 1'b0;
        else     irq_req <= flag & ~cfg.mask;
    end

    assign pin_level = evt.level;

    // R7 R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ($past(flag) && !$past(cfg.mask)));
endmodule

// File: tb/tb_irq_pin_ctrl.sv
`timescale 1ns/1ps
module tb_irq_pin_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_n = 1'b1;
    logic       vec_ack = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_req, pin_level;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_pin_ctrl dut (
        .clk(clk), .rst(rst), .pin_n(pin_n), .vec_ack(vec_ack),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .pin_level(pin_level)
    );

    // {write data, expected read-back}
    localparam logic [15:0] VEC [0:5] = '{
        16'hFF03, 16'h0000, 16'h0101, 16'h0202, 16'hF400, 16'h0703
    };

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(output logic [7:0] v);
        bus_sel = 1'b1;
        bus_we  = 1'b0;
        #0.5;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = v;
        step();
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd(v);
        check(tag, v, exp);
    endtask

    task automatic ack_pulse();
        vec_ack = 1'b1;
        step();
        vec_ack = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(4);
        rst = 1'b0;
        // reset state (R11, R1)
        chk_reg("R11 reset reg", 8'h00);
        check("R11 reset irq", {7'd0, irq_req}, 8'h00);
        check("R1 idle level", {7'd0, pin_level}, 8'h01);

        // R9 table
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][15:8]);
            chk_reg("R9 readback", VEC[i][7:0]);
        end
        wr(8'h00);
        bus_sel = 1'b0;
        #0.5;
        check("R9 unselected read", bus_rdata, 8'h00);

        // R1 R2 R8 edge mode
        pin_n = 1'b0;
        step();
        check("R1 level one edge", {7'd0, pin_level}, 8'h01);
        step();
        check("R1 level two edges", {7'd0, pin_level}, 8'h00);
        chk_reg("R2 flag not yet", 8'h00);
        step();
        chk_reg("R2 flag set", 8'h08);
        check("R8 irq lag", {7'd0, irq_req}, 8'h00);
        step();
        check("R8 irq up", {7'd0, irq_req}, 8'h01);

        // R3 vector acknowledge with pin low
        ack_pulse();
        chk_reg("R3 vec clear", 8'h00);
        step();
        check("R3 irq down", {7'd0, irq_req}, 8'h00);
        step(3);
        chk_reg("R3 no retrigger", 8'h00);
        pin_n = 1'b1; step(3);
        pin_n = 1'b0; step(3);
        chk_reg("R3 set again", 8'h08);
        wr(8'h04);
        chk_reg("R3 sw clear", 8'h00);
        pin_n = 1'b1; step(3);

        // R10 edge beats acknowledge
        pin_n = 1'b0; step(3);
        pin_n = 1'b1; step(3);
        chk_reg("R10 edge mode holds", 8'h08);
        pin_n = 1'b0; step(2);
        ack_pulse();
        chk_reg("R10 edge wins", 8'h08);
        ack_pulse();
        chk_reg("R10 later ack", 8'h00);
        pin_n = 1'b1; step(3);

        // R7 mask
        wr(8'h02);
        pin_n = 1'b0; step(4);
        chk_reg("R7 flag under mask", 8'h0A);
        check("R7 irq masked", {7'd0, irq_req}, 8'h00);
        wr(8'h00);
        check("R7 irq still low", {7'd0, irq_req}, 8'h00);
        step();
        check("R7 irq after unmask", {7'd0, irq_req}, 8'h01);
        wr(8'h04);
        pin_n = 1'b1; step(3);

        // R4 level mode, ack before pin rises
        wr(8'h01);
        pin_n = 1'b0; step(3);
        chk_reg("R4 set", 8'h09);
        ack_pulse();
        chk_reg("R4 ack low holds", 8'h09);
        step(2);
        chk_reg("R4 still held", 8'h09);
        pin_n = 1'b1; step(2);
        chk_reg("R4 level just high", 8'h09);
        step();
        chk_reg("R4 released", 8'h01);

        // R5 pin rises before ack
        pin_n = 1'b0; step(3);
        pin_n = 1'b1; step(4);
        chk_reg("R5 high no ack", 8'h09);
        wr(8'h05);
        chk_reg("R5 ack clears", 8'h01);

        // R6 low level sets without edge
        wr(8'h00);
        pin_n = 1'b0; step(3);
        ack_pulse();
        chk_reg("R6 cleared edge mode", 8'h00);
        wr(8'h01);
        step();
        chk_reg("R6 level sets", 8'h09);
        pin_n = 1'b1;
        ack_pulse();
        step(3);
        chk_reg("R6 cleanup", 8'h01);

        // R11 reset with pin held low
        pin_n = 1'b0; step(3);
        chk_reg("R11 pre reset", 8'h09);
        rst = 1'b1; step(4);
        rst = 1'b0;
        chk_reg("R11 after reset", 8'h00);
        step(3);
        chk_reg("R11 no request", 8'h00);
        check("R11 irq", {7'd0, irq_req}, 8'h00);

        // R12 unselected write
        bus_sel = 1'b0; bus_we = 1'b1; bus_wdata = 8'h03;
        step();
        bus_we = 1'b0; bus_wdata = 8'h00;
        chk_reg("R12 ignored", 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule